// File: doc/BRIEF.md
# Prefetchable Memory Window Decoder

This block keeps the prefetchable memory window of a PCI-to-PCI bridge and decides whether a primary-side memory address lies inside that window, which means the access should be forwarded downstream. The window has 1 MB granularity. The lower 32 bits of its base and limit come from two 16-bit registers in which only the top twelve bits can be written. The upper 32 bits come from two extension registers.

Software reaches the registers through a small configuration port. The port takes a dword index, byte enables, write data and a write strobe, and it returns read data combinationally. Each transaction address arrives with a valid strobe. One clock later the block returns a registered hit flag and a flag that marks the result as valid.

Top module: `pfw_decoder`

## Requirements
- R1: After reset, a read of dword index 9 (offset 24h) returns 0001_0001h, and reads of dword indices 10 and 11 return 0.
- R2: Bits [3:0] of both 16-bit registers always read as 1h. Writes to those bits have no effect.
- R3: Writes follow the byte enables. In dword 9, lanes 0 and 1 write the base register, which sits in read bits [15:0], and lanes 2 and 3 write the limit register, which sits in read bits [31:16]. A lane whose enable is low keeps its old value.
- R4: Register bits [15:4] give address bits [31:20]. The effective base has address bits [19:0] equal to 0, and the effective limit has address bits [19:0] equal to FFFFFh.
- R5: Dword index 10 (offset 28h) holds the upper 32 bits of the base, and dword index 11 (offset 2Ch) holds the upper 32 bits of the limit. Both are fully writable and read back what was written.
- R6: The window is off whenever the full 64-bit base is greater than the full 64-bit limit. While it is off, no address produces a hit.
- R7: When the two upper registers are equal, only the two 16-bit registers decide whether the window is on. A base equal to the limit leaves a single 1 MB block.
- R8: The hit flag is high exactly when the window is on and base <= address <= limit. It is registered, so it appears one cycle after the valid strobe, together with the valid flag. Both flags are low in any cycle that does not follow a strobe.
- R9: After reset the window covers addresses 0 through 000F_FFFFh.
- R10: A read of any other dword index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dword | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_dword |
| txn_valid | input | 1 | Transaction address strobe |
| txn_addr | input | 64 | Transaction memory address |
| hit | output | 1 | Registered result: the address lies inside the window |
| hit_vld | output | 1 | Registered flag: hit carries a result |

## Verification
Read data is combinational, so the bench samples it shortly after it changes the dword index, with no clock edge in between. A configuration write takes effect at the rising edge that captures it, and the bench reads back or probes only after that edge. Hit and its valid flag are due one edge after the strobe. The bench drives each strobe for a single cycle at a falling edge and checks both flags at the next falling edge. It also checks that both flags return low when no strobe is present.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int ADDR_W   = 64;
  localparam int GRAN_W   = 20;           // 1 MB granularity
  localparam int FIELD_W  = 32 - GRAN_W;  // writable field width
  localparam int UPPER_W  = ADDR_W - 32;

  function automatic logic [ADDR_W-1:0] base_of(input logic [UPPER_W-1:0] up,
                                                input logic [FIELD_W-1:0] fld);
    return {up, fld, {GRAN_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] limit_of(input logic [UPPER_W-1:0] up,
                                                 input logic [FIELD_W-1:0] fld);
    return {up, fld, {GRAN_W{1'b1}}};
  endfunction

  function automatic logic [7:0] lane_merge(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic en);
    return en ? new_v : old_v;
  endfunction
endpackage

// File: rtl/pfw_cfg_regs.sv
module pfw_cfg_regs
  import pfw_pkg::*;
#(
  parameter int CFG_AW  = 6,
  parameter int DW_PAIR = 9,
  parameter int DW_UBAS = 10,
  parameter int DW_ULIM = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_AW-1:0]  cfg_dword,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic [FIELD_W-1:0] base_fld,
  output logic [FIELD_W-1:0] lim_fld,
  output logic [UPPER_W-1:0] base_up,
  output logic [UPPER_W-1:0] lim_up
);
  localparam logic [3:0] HW_NIB = 4'h1;

  logic sel_pair, sel_ubas, sel_ulim;
  assign sel_pair = cfg_wr && (cfg_dword == CFG_AW'(DW_PAIR));
  assign sel_ubas = cfg_wr && (cfg_dword == CFG_AW'(DW_UBAS));
  assign sel_ulim = cfg_wr && (cfg_dword == CFG_AW'(DW_ULIM));

  // Paired 16-bit registers: only bits [15:4] are stored.
  logic [15:0] base_img, lim_img, base_nxt, lim_nxt;
  assign base_img = {base_fld, HW_NIB};
  assign lim_img  = {lim_fld,  HW_NIB};
  assign base_nxt = {lane_merge(base_img[15:8], cfg_wdata[15:8],  cfg_be[1]),
                     lane_merge(base_img[7:0],  cfg_wdata[7:0],   cfg_be[0])};
  assign lim_nxt  = {lane_merge(lim_img[15:8],  cfg_wdata[31:24], cfg_be[3]),
                     lane_merge(lim_img[7:0],   cfg_wdata[23:16], cfg_be[2])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_fld <= '0;
      lim_fld  <= '0;
    end else if (sel_pair) begin
      base_fld <= base_nxt[15:4];
      lim_fld  <= lim_nxt[15:4];
    end
  end

  // Upper 32-bit extensions, one flop group per byte lane.
  for (genvar g = 0; g < 4; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_up[g*8 +: 8] <= '0;
        lim_up[g*8 +: 8]  <= '0;
      end else begin
        if (sel_ubas && cfg_be[g]) base_up[g*8 +: 8] <= cfg_wdata[g*8 +: 8];
        if (sel_ulim && cfg_be[g]) lim_up[g*8 +: 8]  <= cfg_wdata[g*8 +: 8];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_dword == CFG_AW'(DW_PAIR))      cfg_rdata = {lim_img, base_img};
    else if (cfg_dword == CFG_AW'(DW_UBAS)) cfg_rdata = base_up;
    else if (cfg_dword == CFG_AW'(DW_ULIM)) cfg_rdata = lim_up;
  end

  // R3: a write with no enabled lane leaves every register unchanged
  a_r3_no_lane_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be == 4'b0000) |=> ($stable(base_up) && $stable(lim_up)
                                      && $stable(base_fld) && $stable(lim_fld)));

  // R5: a full write to the upper base register is seen on the next cycle
  a_r5_upper_base_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ubas && cfg_be == 4'hF) |=> (base_up == $past(cfg_wdata)));

  // R2: the read image of the pair always shows 1h in both low nibbles
  a_r2_nibble_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dword == CFG_AW'(DW_PAIR)) |-> (cfg_rdata[3:0] == 4'h1 && cfg_rdata[19:16] == 4'h1));
endmodule

// File: rtl/pfw_range_cmp.sv
module pfw_range_cmp
  import pfw_pkg::*;
(
  input  logic [FIELD_W-1:0] base_fld,
  input  logic [FIELD_W-1:0] lim_fld,
  input  logic [UPPER_W-1:0] base_up,
  input  logic [UPPER_W-1:0] lim_up,
  input  logic [ADDR_W-1:0]  addr,
  output logic [ADDR_W-1:0]  base_eff,
  output logic [ADDR_W-1:0]  lim_eff,
  output logic               win_en,
  output logic               in_win
);
  assign base_eff = base_of(base_up, base_fld);
  assign lim_eff  = limit_of(lim_up, lim_fld);
  assign win_en   = (base_eff <= lim_eff);
  assign in_win   = win_en && (addr >= base_eff) && (addr <= lim_eff);

  // R7: equal upper halves leave the decision to the 12-bit fields
  always_comb begin
    if (base_up == lim_up)
      a_r7_lower_decides: assert (win_en == (base_fld <= lim_fld));
  end
endmodule

// File: rtl/pfw_decoder.sv
module pfw_decoder
  import pfw_pkg::*;
#(
  parameter int CFG_AW  = 6,
  parameter int DW_PAIR = 9,
  parameter int DW_UBAS = 10,
  parameter int DW_ULIM = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_dword,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              txn_valid,
  input  logic [63:0]       txn_addr,
  output logic              hit,
  output logic              hit_vld
);
  logic [FIELD_W-1:0] base_fld, lim_fld;
  logic [UPPER_W-1:0] base_up, lim_up;
  logic [ADDR_W-1:0]  base_eff, lim_eff;
  logic               win_en, in_win;

  pfw_cfg_regs #(
    .CFG_AW(CFG_AW), .DW_PAIR(DW_PAIR), .DW_UBAS(DW_UBAS), .DW_ULIM(DW_ULIM)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dword(cfg_dword),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .base_fld(base_fld), .lim_fld(lim_fld), .base_up(base_up), .lim_up(lim_up)
  );

  pfw_range_cmp u_cmp (
    .base_fld(base_fld), .lim_fld(lim_fld), .base_up(base_up), .lim_up(lim_up),
    .addr(txn_addr), .base_eff(base_eff), .lim_eff(lim_eff),
    .win_en(win_en), .in_win(in_win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      hit_vld <= 1'b0;
    end else begin
      hit     <= txn_valid && in_win;
      hit_vld <= txn_valid;
    end
  end

  // R8: a hit only follows a strobe
  a_r8_hit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(txn_valid));

  // R8: the valid flag tracks the strobe one cycle later
  a_r8_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> hit_vld);

  // R6: no hit while the window was off
  a_r6_no_hit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(win_en));

  // R4: a hit address lay between the effective bounds
  a_r4_hit_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(txn_addr) >= $past(base_eff) && $past(txn_addr) <= $past(lim_eff)));
endmodule

// File: tb/pfw_decoder_bench.sv
module pfw_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dword = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        txn_valid = 1'b0;
  logic [63:0] txn_addr = '0;
  logic        hit, hit_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfw_decoder u_pfw_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dword(cfg_dword),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .txn_valid(txn_valid), .txn_addr(txn_addr), .hit(hit), .hit_vld(hit_vld)
  );

  // Window for the table: base 1_0120_0000h, limit 1_034F_FFFFh
  localparam int NV = 8;
  localparam logic [64:0] VEC [NV] = '{
    {64'h0000_0001_0120_0000, 1'b1},
    {64'h0000_0001_011F_FFFF, 1'b0},
    {64'h0000_0001_034F_FFFF, 1'b1},
    {64'h0000_0001_0350_0000, 1'b0},
    {64'h0000_0001_0200_0000, 1'b1},
    {64'h0000_0000_0200_0000, 1'b0},
    {64'h0000_0002_0200_0000, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b0}
  };

  task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dword = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_check(input logic [5:0] dw, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_dword = dw;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read dw %0d: got %h expected %h", req, dw, cfg_rdata, exp);
    end
  endtask

  task automatic probe(input logic [63:0] a, input logic exp, input string req);
    @(negedge clk);
    txn_valid = 1'b1; txn_addr = a;
    @(negedge clk);
    txn_valid = 1'b0;
    checks++;
    if (hit !== exp || hit_vld !== 1'b1) begin
      errors++;
      $display("FAIL %s addr %h: got hit=%b vld=%b expected hit=%b vld=1",
               req, a, hit, hit_vld, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_check(6'd9,  32'h0001_0001, "R1");
    cfg_check(6'd10, 32'h0, "R1");
    cfg_check(6'd11, 32'h0, "R1");
    checks++;
    if (hit !== 1'b0 || hit_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 flags after reset: got %b%b expected 00", hit, hit_vld);
    end
    // R9 reset window is the bottom 1 MB
    probe(64'h0, 1'b1, "R9");
    probe(64'h000F_FFFF, 1'b1, "R9");
    probe(64'h0010_0000, 1'b0, "R9");

    // Configure the table window (R4, R5)
    cfg_write(6'd9,  4'hF, 32'h0340_0120);
    cfg_write(6'd10, 4'hF, 32'h1);
    cfg_write(6'd11, 4'hF, 32'h1);
    cfg_check(6'd9,  32'h0341_0121, "R4");
    cfg_check(6'd10, 32'h1, "R5");
    cfg_check(6'd11, 32'h1, "R5");

    for (int i = 0; i < NV; i++) probe(VEC[i][64:1], VEC[i][0], "R4");

    // R3 byte enables: only base low lane
    cfg_write(6'd9, 4'b0001, 32'hFFFF_FFFF);
    cfg_check(6'd9, 32'h0341_01F1, "R3");
    cfg_write(6'd9, 4'b1000, 32'h5500_0000);
    cfg_check(6'd9, 32'h5541_01F1, "R3");
    cfg_write(6'd10, 4'b0010, 32'hAAAA_AAAA);
    cfg_check(6'd10, 32'h0000_AA01, "R3");
    cfg_write(6'd10, 4'hF, 32'h1);

    // R2 low nibble hardwired
    cfg_write(6'd9, 4'hF, 32'h0000_0000);
    cfg_check(6'd9, 32'h0001_0001, "R2");
    cfg_write(6'd9, 4'hF, 32'h034E_012E);
    cfg_check(6'd9, 32'h0341_0121, "R2");
    probe(64'h0000_0001_0120_0000, 1'b1, "R2");

    // R6 upper base above upper limit: window off
    cfg_write(6'd10, 4'hF, 32'h2);
    probe(64'h0000_0001_0200_0000, 1'b0, "R6");
    probe(64'h0000_0002_0200_0000, 1'b0, "R6");
    // Upper base below upper limit: wide window despite lower fields
    cfg_write(6'd10, 4'hF, 32'h1);
    cfg_write(6'd11, 4'hF, 32'h2);
    cfg_write(6'd9,  4'hF, 32'h0010_0FF0);
    probe(64'h0000_0001_FFFF_FFFF, 1'b1, "R6");
    probe(64'h0000_0002_0000_0000, 1'b1, "R6");
    probe(64'h0000_0002_0020_0000, 1'b0, "R6");

    // R7 equal upper halves, lower base above lower limit: off
    cfg_write(6'd11, 4'hF, 32'h1);
    cfg_write(6'd9,  4'hF, 32'h0340_0350);
    probe(64'h0000_0001_0345_0000, 1'b0, "R7");
    probe(64'h0000_0001_0350_0000, 1'b0, "R7");
    // Equal fields: a single 1 MB block
    cfg_write(6'd9, 4'hF, 32'h0340_0340);
    probe(64'h0000_0001_0340_0000, 1'b1, "R7");
    probe(64'h0000_0001_034F_FFFF, 1'b1, "R7");
    probe(64'h0000_0001_0350_0000, 1'b0, "R7");

    // R8 no strobe: both flags low one cycle later
    @(negedge clk);
    txn_addr = 64'h0000_0001_0340_0000;
    @(negedge clk);
    checks++;
    if (hit !== 1'b0 || hit_vld !== 1'b0) begin
      errors++;
      $display("FAIL R8 without strobe: got hit=%b vld=%b expected 0 0", hit, hit_vld);
    end

    // R10 other offsets read zero
    cfg_check(6'd0,  32'h0, "R10");
    cfg_check(6'd12, 32'h0, "R10");
    cfg_check(6'd8,  32'h0, "R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule